// File: doc/BRIEF.md
# Memory Bridge to a Host Reached over SPI

This block presents a Wishbone slave that a processor addresses like ordinary RAM. No storage sits inside it. Each access is parked inside the block. A remote host then fetches the access details and carries out the access in its own memory. The host is the SPI master and the block is the SPI slave. The block cannot start a conversation, so the host polls it repeatedly. A poll returns the parked address, direction, byte selects and write data. The host answers with read data or with a write completion. Only then does the Wishbone side see its acknowledge, so the latency of an access has no fixed bound.

Everything runs from the single system clock. The SPI clock, chip select and data-in pins are treated as ordinary asynchronous inputs. They pass through a short synchronizer, and a two-state tracker of the sampled clock level turns them into rising and falling edge strobes. The system clock must run at more than twice the SPI clock. The bench uses at least six system clocks per SPI half period.

Top module: `spi_wb_bridge`

## Requirements
- R1: While reset is high and in the cycle after it, `wb_ack_o`, `wb_stall_o` and `spi_miso_o` are all 0.
- R2: When no access is parked, `wb_stall_o` is 0 and a cycle with `wb_cyc_i` and `wb_stb_i` high parks the access. From the next cycle until and including the acknowledge cycle, `wb_stall_o` is 1.
- R3: Strobes that arrive while an access is parked are ignored. A later poll still reports the first access.
- R4: Without a completing host frame, no acknowledge is given, however long the wait.
- R5: A frame lasts while `spi_csn_i` is low. It uses SPI mode 0: data-in is sampled on the rising SCK edge and `spi_miso_o` changes after the falling edge, MSB first. The first 8 bits are a command code. Raising chip select restarts the framing.
- R6: Command 0x01 (poll) makes the block return 72 bits after the command byte. The first is a status byte: bit 0 is parked, bit 1 is write, bits 3:2 are 0 and bits 7:4 are the byte selects. The address follows in 32 bits, then the write data in 32 bits. When nothing is parked, all 72 bits are 0.
- R7: Command 0x02 followed by 32 data bits completes a parked read. `wb_ack_o` is high for exactly one cycle with `wb_dat_o` equal to those bits.
- R8: Command 0x03 completes a parked write with a single-cycle `wb_ack_o`.
- R9: A read-data frame whose chip select rises before all 32 data bits are in has no effect. The access stays parked.
- R10: A completion command that does not match the parked direction, or that arrives with nothing parked, is ignored.
- R11: In the cycle after the acknowledge, `wb_stall_o` is 0 and a poll reports nothing parked.
- R12: `spi_miso_o` is 0 from the cycle after chip select is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | ADDR_W | Wishbone address |
| wb_dat_i | input | DATA_W | Wishbone write data |
| wb_sel_i | input | DATA_W/8 | Wishbone byte selects |
| wb_dat_o | output | DATA_W | Read data returned with the acknowledge |
| wb_ack_o | output | 1 | Single-cycle acknowledge |
| wb_stall_o | output | 1 | Access cannot be taken this cycle |
| spi_sck_i | input | 1 | SPI clock from the host, asynchronous |
| spi_csn_i | input | 1 | SPI chip select, active low, asynchronous |
| spi_mosi_i | input | 1 | SPI data from the host |
| spi_miso_o | output | 1 | SPI data to the host |

## Verification
The bench waits hundreds of cycles with a write parked. A design that acknowledges on a timer would show an early acknowledge there. It sends a stray strobe during a parked access, and a design that re-latches would report the wrong address in the next poll. It cuts a read-data frame short after 16 bits and sends completion commands of the wrong kind, including one with nothing parked. A design that fires on a partial count or ignores direction would hand back a spurious acknowledge, which the scoreboard flags as unexpected. It also checks that stall drops exactly one cycle after the acknowledge, because a bridge that re-accepts a held classic strobe during the acknowledge cycle would issue a phantom second access.

// File: rtl/spi_wb_bridge_pkg.sv
package spi_wb_bridge_pkg;

  localparam int CMD_W      = 8;
  localparam int STATUS_W   = 8;
  localparam int SEL_FIELD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_POLL  = 8'h01,
    CMD_RDATA = 8'h02,
    CMD_WACK  = 8'h03
  } host_cmd_e;

  typedef enum logic {
    SCK_LOW  = 1'b0,
    SCK_HIGH = 1'b1
  } sck_state_e;

endpackage

// File: rtl/spi_pin_sampler.sv
// Brings the asynchronous SPI pins into the system clock domain and
// turns the sampled SCK level into rising and falling edge strobes.
module spi_pin_sampler
  import spi_wb_bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic mosi_o,
  output logic cs_act_o
);

  localparam logic [2:0] PIN_IDLE = 3'b100; // csn high, mosi low, sck low

  logic [2:0] pipe_q [SYNC_STAGES];
  logic [2:0] pins_s;
  sck_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= PIN_IDLE;
    end else begin
      pipe_q[0] <= {csn_i, mosi_i, sck_i};
      for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign pins_s = pipe_q[SYNC_STAGES-1];

  // Two-state tracker of the last sampled clock level.
  always_ff @(posedge clk) begin
    if (rst) state_q <= SCK_LOW;
    else     state_q <= pins_s[0] ? SCK_HIGH : SCK_LOW;
  end

  assign sck_rise_o = (state_q == SCK_LOW)  &&  pins_s[0];
  assign sck_fall_o = (state_q == SCK_HIGH) && !pins_s[0];
  assign mosi_o     = pins_s[1];
  assign cs_act_o   = !pins_s[2];

endmodule

// File: rtl/wb_req_holder.sv
// Parks one Wishbone access until the host side signals completion.
module wb_req_holder #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic [SEL_W-1:0]  wb_sel_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic              wb_stall_o,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              pend_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] adr_o,
  output logic [DATA_W-1:0] dat_o,
  output logic [SEL_W-1:0]  sel_o
);

  logic              pend_q, ack_q, we_q;
  logic [ADDR_W-1:0] adr_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic [SEL_W-1:0]  sel_q;
  logic              accept;

  // No capture during the acknowledge cycle: a classic master still
  // holds its strobe there.
  assign accept = wb_cyc_i && wb_stb_i && !pend_q && !ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
      we_q   <= 1'b0;
      adr_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      sel_q  <= '0;
    end else begin
      ack_q <= 1'b0;
      if (accept) begin
        pend_q <= 1'b1;
        we_q   <= wb_we_i;
        adr_q  <= wb_adr_i;
        wdat_q <= wb_dat_i;
        sel_q  <= wb_sel_i;
      end
      if (done_i && pend_q) begin
        pend_q <= 1'b0;
        ack_q  <= 1'b1;
        if (!we_q) rdat_q <= rdata_i;
      end
    end
  end

  assign wb_ack_o   = ack_q;
  assign wb_dat_o   = rdat_q;
  assign wb_stall_o = pend_q || ack_q;
  assign pend_o     = pend_q;
  assign we_o       = we_q;
  assign adr_o      = adr_q;
  assign dat_o      = wdat_q;
  assign sel_o      = sel_q;

endmodule

// File: rtl/spi_host_frame.sv
// Frame engine: command byte, status shift-out, read-data shift-in.
module spi_host_frame
  import spi_wb_bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int SEL_W = DATA_W / 8,
  localparam int TX_W  = STATUS_W + ADDR_W + DATA_W,
  localparam int CNT_MAX_I = CMD_W + TX_W,
  localparam int CNT_W = $clog2(CNT_MAX_I + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              mosi_i,
  input  logic              cs_act_i,
  input  logic              pend_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              miso_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(CNT_MAX_I);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CMD_DONE  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(CMD_W + DATA_W - 1);

  logic [CNT_W-1:0]       bit_cnt_q;
  logic [CMD_W-1:0]       cmd_q, cmd_shift;
  logic [DATA_W-1:0]      rx_q, rx_shift, rdata_q;
  logic [TX_W-1:0]        tx_q, snapshot;
  logic [STATUS_W-1:0]    status;
  logic [SEL_FIELD_W-1:0] sel_field;
  logic                   miso_q, done_q;

  always_comb begin
    cmd_shift = {cmd_q[CMD_W-2:0], mosi_i};
    rx_shift  = {rx_q[DATA_W-2:0], mosi_i};
    sel_field = SEL_FIELD_W'(sel_i);
    status    = {sel_field, 2'b00, we_i, pend_i};
    snapshot  = pend_i ? {status, adr_i, dat_i} : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt_q <= '0;
      cmd_q     <= '0;
      rx_q      <= '0;
      rdata_q   <= '0;
      tx_q      <= '0;
      miso_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!cs_act_i) begin
        bit_cnt_q <= '0;
        tx_q      <= '0;
        miso_q    <= 1'b0;
      end else begin
        if (sck_rise_i) begin
          if (bit_cnt_q != CNT_MAX) bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q < CMD_DONE) cmd_q <= cmd_shift;
          else                      rx_q  <= rx_shift;
          if (bit_cnt_q == CMD_LAST) begin
            if (cmd_shift == CMD_POLL) tx_q <= snapshot;
            if (cmd_shift == CMD_WACK && pend_i && we_i) done_q <= 1'b1;
          end
          if (bit_cnt_q == DATA_LAST && cmd_q == CMD_RDATA && pend_i && !we_i) begin
            done_q  <= 1'b1;
            rdata_q <= rx_shift;
          end
        end
        if (sck_fall_i && cmd_q == CMD_POLL && bit_cnt_q >= CMD_DONE) begin
          miso_q <= tx_q[TX_W-1];
          tx_q   <= {tx_q[TX_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso_o  = miso_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/spi_wb_bridge.sv
module spi_wb_bridge #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic [SEL_W-1:0]  wb_sel_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic              wb_stall_o,
  input  logic              spi_sck_i,
  input  logic              spi_csn_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o
);

  logic              sck_rise, sck_fall, mosi_s, cs_act;
  logic              host_done;
  logic [DATA_W-1:0] host_rdata;
  logic              pend, pend_we;
  logic [ADDR_W-1:0] pend_adr;
  logic [DATA_W-1:0] pend_dat;
  logic [SEL_W-1:0]  pend_sel;

  spi_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst(rst),
    .sck_i(spi_sck_i), .csn_i(spi_csn_i), .mosi_i(spi_mosi_i),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .mosi_o(mosi_s), .cs_act_o(cs_act)
  );

  wb_req_holder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_sel_i(wb_sel_i),
    .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o), .wb_stall_o(wb_stall_o),
    .done_i(host_done), .rdata_i(host_rdata),
    .pend_o(pend), .we_o(pend_we), .adr_o(pend_adr),
    .dat_o(pend_dat), .sel_o(pend_sel)
  );

  spi_host_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .mosi_i(mosi_s), .cs_act_i(cs_act),
    .pend_i(pend), .we_i(pend_we), .adr_i(pend_adr),
    .dat_i(pend_dat), .sel_i(pend_sel),
    .miso_o(spi_miso_o), .done_o(host_done), .rdata_o(host_rdata)
  );

endmodule

// File: rtl/spi_wb_bridge_chk.sv
module spi_wb_bridge_chk (
  input logic clk,
  input logic rst,
  input logic wb_cyc_i,
  input logic wb_stb_i,
  input logic wb_ack_o,
  input logic wb_stall_o,
  input logic spi_miso_o,
  input logic done_i,
  input logic cs_act_i
);

  // R2: a taken access makes the block busy in the next cycle
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_i && wb_stb_i && !wb_stall_o) |=> (wb_stall_o && !wb_ack_o));

  // R4: stall is never dropped before the acknowledge
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_stall_o && !wb_ack_o) |=> wb_stall_o);

  // R7: the acknowledge lasts a single cycle
  assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |=> !wb_ack_o);

  // R8: an acknowledge follows a completion from the frame engine
  assert_ack_from_host_R8: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |-> $past(done_i));

  // R10: no acknowledge without a parked access
  assert_ack_needs_pend_R10: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |-> $past(wb_stall_o));

  // R12: data-out is quiet once chip select is seen high
  assert_miso_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !cs_act_i |=> !spi_miso_o);

endmodule

bind spi_wb_bridge spi_wb_bridge_chk u_chk (
  .clk(clk), .rst(rst),
  .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
  .wb_ack_o(wb_ack_o), .wb_stall_o(wb_stall_o),
  .spi_miso_o(spi_miso_o), .done_i(host_done), .cs_act_i(cs_act)
);

// File: tb/spi_wb_bridge_test.sv
module spi_wb_bridge_test;
  localparam int AW = 32, DW = 32, SW = DW / 8, HALF = 6;
  localparam int RW = 8 + AW + DW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, wb_cyc, wb_stb, wb_we, wb_ack, wb_stall;
  logic [AW-1:0] wb_adr;
  logic [DW-1:0] wb_wdat, wb_rdat;
  logic [SW-1:0] wb_sel;
  logic sck, csn, mosi, miso;

  int checks = 0, fails = 0, acks_seen = 0;
  bit finished = 1'b0;

  typedef struct packed { logic rd; logic [DW-1:0] d; } exp_t;
  exp_t exp_q[$];

  spi_wb_bridge uut (
    .clk(clk), .rst(rst),
    .wb_cyc_i(wb_cyc), .wb_stb_i(wb_stb), .wb_we_i(wb_we),
    .wb_adr_i(wb_adr), .wb_dat_i(wb_wdat), .wb_sel_i(wb_sel),
    .wb_dat_o(wb_rdat), .wb_ack_o(wb_ack), .wb_stall_o(wb_stall),
    .spi_sck_i(sck), .spi_csn_i(csn), .spi_mosi_i(mosi), .spi_miso_o(miso)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wb_ack) begin
      exp_t e;
      acks_seen++;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected ack actual=1 expected=0");
      end else begin
        e = exp_q.pop_front();
        if (e.rd) check(wb_rdat == e.d, "R7 read data", wb_rdat, e.d);
        else      check(1'b1, "R8 write ack", 32'd1, 32'd1);
      end
    end
  end

  task automatic spi_bit(input logic b, output logic r);
    mosi = b;
    repeat (HALF) @(negedge clk);
    r = miso;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic spi_open();
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic spi_close();
    repeat (HALF) @(negedge clk);
    csn = 1'b1; mosi = 1'b0;
    repeat (2*HALF) @(negedge clk);
    check(miso == 1'b0, "R12 miso idle", {31'b0, miso}, 32'd0);
  endtask

  task automatic spi_cmd(input logic [7:0] c);
    logic r;
    for (int i = 7; i >= 0; i--) spi_bit(c[i], r);
  endtask

  task automatic host_poll(output logic [7:0] st, output logic [AW-1:0] a, output logic [DW-1:0] d);
    logic [RW-1:0] sh;
    logic r;
    sh = '0;
    spi_open();
    spi_cmd(8'h01);
    for (int i = 0; i < RW; i++) begin
      spi_bit(1'b0, r);
      sh = {sh[RW-2:0], r};
    end
    spi_close();
    {st, a, d} = sh;
  endtask

  task automatic host_rdata(input logic [DW-1:0] d, input int nbits);
    logic r;
    spi_open();
    spi_cmd(8'h02);
    for (int i = 0; i < nbits; i++) spi_bit(d[DW-1-i], r);
    spi_close();
  endtask

  task automatic host_wack();
    spi_open();
    spi_cmd(8'h03);
    spi_close();
  endtask

  task automatic wb_issue(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SW-1:0] s);
    @(negedge clk);
    check(wb_stall == 1'b0, "R2 idle stall", {31'b0, wb_stall}, 32'd0);
    wb_cyc = 1'b1; wb_stb = 1'b1; wb_we = we; wb_adr = a; wb_wdat = d; wb_sel = s;
    @(negedge clk);
    wb_stb = 1'b0;
    check(wb_stall == 1'b1, "R2 busy after accept", {31'b0, wb_stall}, 32'd1);
  endtask

  task automatic wb_stray(input logic [AW-1:0] a);
    @(negedge clk);
    check(wb_stall == 1'b1, "R3 stall while parked", {31'b0, wb_stall}, 32'd1);
    wb_stb = 1'b1; wb_adr = a; wb_we = ~wb_we; wb_sel = ~wb_sel;
    @(negedge clk);
    wb_stb = 1'b0;
  endtask

  task automatic wait_ack();
    int n;
    n = 0;
    while (wb_ack !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(wb_ack === 1'b1, "R7 R8 ack arrives", {31'b0, wb_ack}, 32'd1);
    check(wb_stall == 1'b1, "R2 stall in ack cycle", {31'b0, wb_stall}, 32'd1);
    @(negedge clk);
    check(wb_ack == 1'b0, "R7 one-cycle ack", {31'b0, wb_ack}, 32'd0);
    check(wb_stall == 1'b0, "R11 stall clears", {31'b0, wb_stall}, 32'd0);
    wb_cyc = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int base;
    rst = 1'b1; wb_cyc = 1'b0; wb_stb = 1'b0; wb_we = 1'b0;
    wb_adr = '0; wb_wdat = '0; wb_sel = '0;
    sck = 1'b0; csn = 1'b1; mosi = 1'b0;
    repeat (5) @(negedge clk);
    check(wb_ack == 1'b0, "R1 ack reset", {31'b0, wb_ack}, 32'd0);
    check(wb_stall == 1'b0, "R1 stall reset", {31'b0, wb_stall}, 32'd0);
    check(miso == 1'b0, "R1 miso reset", {31'b0, miso}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(wb_ack == 1'b0 && wb_stall == 1'b0, "R1 after release", {30'b0, wb_ack, wb_stall}, 32'd0);

    // Idle poll returns all zero
    host_poll(st, a, d);
    check(st == 8'h00, "R6 idle status (R5 framing)", {24'b0, st}, 32'd0);
    check(a == '0 && d == '0, "R6 idle address/data", a ^ d, 32'd0);

    // Write completion with nothing parked is ignored
    host_wack();
    repeat (20) @(negedge clk);
    check(acks_seen == 0, "R10 wack when idle", acks_seen, 32'd0);

    // Parked write
    wb_issue(1'b1, 32'h8000_1234, 32'hDEAD_BEEF, 4'b1010);
    repeat (400) @(negedge clk);
    check(acks_seen == 0, "R4 no ack without host", acks_seen, 32'd0);
    check(wb_stall == 1'b1, "R4 still stalled", {31'b0, wb_stall}, 32'd1);
    host_poll(st, a, d);
    check(st == 8'hA3, "R6 write status", {24'b0, st}, 32'hA3);
    check(a == 32'h8000_1234, "R6 write address", a, 32'h8000_1234);
    check(d == 32'hDEAD_BEEF, "R6 write data", d, 32'hDEAD_BEEF);
    wb_stray(32'h1111_0000);
    host_poll(st, a, d);
    check(a == 32'h8000_1234, "R3 stray strobe ignored", a, 32'h8000_1234);
    check(st == 8'hA3, "R3 status unchanged", {24'b0, st}, 32'hA3);
    host_rdata(32'h5555_AAAA, 32);
    repeat (20) @(negedge clk);
    check(acks_seen == 0, "R10 read data while write parked", acks_seen, 32'd0);
    exp_q.push_back('{rd: 1'b0, d: '0});
    fork
      host_wack();
      wait_ack();
    join
    check(acks_seen == 1, "R8 write completed", acks_seen, 32'd1);

    // Parked read
    wb_issue(1'b0, 32'h0000_0040, 32'h0, 4'b1111);
    host_poll(st, a, d);
    check(st == 8'hF1, "R6 read status", {24'b0, st}, 32'hF1);
    check(a == 32'h0000_0040, "R6 read address", a, 32'h40);
    host_wack();
    repeat (20) @(negedge clk);
    check(acks_seen == 1, "R10 wack while read parked", acks_seen, 32'd1);
    host_rdata(32'hCAFE_F00D, 16);
    repeat (20) @(negedge clk);
    check(acks_seen == 1, "R9 short frame no ack", acks_seen, 32'd1);
    host_poll(st, a, d);
    check(st == 8'hF1, "R9 still parked", {24'b0, st}, 32'hF1);
    exp_q.push_back('{rd: 1'b1, d: 32'h1234_5678});
    fork
      host_rdata(32'h1234_5678, 32);
      wait_ack();
    join

    // Second read, other pattern, issued right after completion
    base = acks_seen;
    wb_issue(1'b0, 32'hFFFF_FFFC, 32'h0, 4'b0011);
    host_poll(st, a, d);
    check(st == 8'h31, "R6 partial selects", {24'b0, st}, 32'h31);
    check(a == 32'hFFFF_FFFC, "R6 high address", a, 32'hFFFF_FFFC);
    exp_q.push_back('{rd: 1'b1, d: 32'hA5A5_5A5A});
    fork
      host_rdata(32'hA5A5_5A5A, 32);
      wait_ack();
    join
    check(acks_seen == base + 1, "R7 second read", acks_seen, base + 1);

    host_poll(st, a, d);
    check(st == 8'h00, "R11 idle after completion", {24'b0, st}, 32'd0);
    check(exp_q.size() == 0, "R7 R8 all expected acks seen", exp_q.size(), 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule